// File: doc/BRIEF.md
# LFSR Raster Timing Generator

This block produces every timing signal that a hardwired ball-and-paddle game needs to draw its picture. The master clock is divided down to a one-clock pixel enable. A 7-bit shift-register counter with XNOR feedback steps once per pixel, and an 8-bit shift-register counter steps once every second line. Both are truncated by decoding fixed states, so no binary adders or magnitude comparators are needed.

Exact-state compares on the two counters produce strobes for the screen landmarks: the two side walls, the centre line, the top and bottom borders and the band that holds the score digits. Set/reset latches, set and cleared by the same kind of strobe, form the horizontal and vertical sync pulses, the active-picture window and the score band. Game logic blocks read the raw counter states and strobes, and the display path takes the blanking and active-low composite sync.

Top module: `raster_timer`

## Requirements
- R1: `pix_en` is high for exactly one clock in every `DIV` clocks (default 2). It is high on the clock numbered `DIV-1, 2*DIV-1, ...`, counting from 0 at the first clock after reset is released.
- R2: A line is 128 pixel slots. `h_state` is 7'h00 in slot 0. For slots 1 to 126 it is the previous state shifted left by one, with the XNOR of bits 6 and 0 entering bit 0. In slot 127 it is 7'h7F, and slot 0 of the next line follows.
- R3: A field is 262 lines. `v_odd` is the line number modulo 2. `v_state` is 8'h00 on lines 0 and 1. After each odd line it shifts left by one, with the XNOR of bits 7 and 4 entering bit 0. Line 0 follows line 261.
- R4: `left_wall`, `center_line` and `right_wall` are high for the whole of slot 22, slot 62 and slot 98 respectively, and low otherwise.
- R5: `top_border` is high for the whole of line 42 and `bottom_border` for the whole of line 232. `score_band` is high for lines 44 to 68 inclusive.
- R6: `hsync` is high in slots 120 to 127, which is 8 slots per line.
- R7: `vsync` is high for the whole of lines 258 to 261, which is 4 lines per field.
- R8: `csync_n` is low exactly when `hsync` or `vsync` is high.
- R9: `blank` is low exactly when the slot is within 24 to 96 (73 pixels) and the line is within 40 to 231 (192 lines).
- R10: Reset is synchronous and active low. A clock edge with `rst_n` low returns the block to slot 0 of line 0 with `pix_en` low and every latch cleared, even in the middle of a sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | output | 1 | One-clock pixel enable |
| h_state | output | 7 | Horizontal shift-register state |
| v_state | output | 8 | Vertical shift-register state |
| v_odd | output | 1 | Line parity within the field |
| left_wall | output | 1 | Left wall column strobe |
| center_line | output | 1 | Centre line column strobe |
| right_wall | output | 1 | Right wall column strobe |
| top_border | output | 1 | Top border line strobe |
| bottom_border | output | 1 | Bottom border line strobe |
| score_band | output | 1 | High on the score digit lines |
| blank | output | 1 | High outside the active picture |
| hsync | output | 1 | Horizontal sync latch |
| vsync | output | 1 | Vertical sync latch |
| csync_n | output | 1 | Composite sync, active low |

## Verification
The strobes and the counter states are combinational views of registers that change on the edge where `pix_en` is high. Each of them is therefore due in the clock that directly follows that edge, and it holds for `DIV` clocks. Latches are set on the enable edge of the slot or line before the first active one, so `hsync`, `blank` and `score_band` change one registered step after their set decode. The bench counts the clock edges since reset and derives the slot and the line from that count. It compares every output at the falling edge, after all registers of the current cycle have settled.

// File: rtl/rt_pkg.sv
// Package: shared constants and state-stepping functions for the raster
// timing generator. Assumes the fixed tap positions of both counters; the
// functions are used at elaboration time to find decode states.
package rt_pkg;

    localparam int H_W = 7;
    localparam int V_W = 8;
    localparam logic [H_W-1:0] H_START = '0;
    localparam logic [V_W-1:0] V_START = '0;
    localparam logic [H_W-1:0] H_PARK  = '1;

    // One horizontal step: shift left, XNOR of bits 6 and 0 enters bit 0.
    function automatic logic [H_W-1:0] h_step(input logic [H_W-1:0] s);
        return {s[H_W-2:0], ~(s[H_W-1] ^ s[0])};
    endfunction

    // One vertical step: shift left, XNOR of bits 7 and 4 enters bit 0.
    function automatic logic [V_W-1:0] v_step(input logic [V_W-1:0] s);
        return {s[V_W-2:0], ~(s[7] ^ s[4])};
    endfunction

    // Horizontal state reached n steps after the line start (n < 127).
    function automatic logic [H_W-1:0] h_at(input int n);
        logic [H_W-1:0] s;
        s = H_START;
        for (int i = 0; i < n; i++) s = h_step(s);
        return s;
    endfunction

    // Vertical state reached k steps after the field start.
    function automatic logic [V_W-1:0] v_at(input int k);
        logic [V_W-1:0] s;
        s = V_START;
        for (int i = 0; i < k; i++) s = v_step(s);
        return s;
    endfunction

endpackage

// File: rtl/rt_clk_div.sv
// Module: divides the master clock to a one-clock pixel enable.
// Assumes DIV >= 2; the enable is high on the last count of each period.
module rt_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic pix_en
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign pix_en = (cnt == LAST);
endmodule

// File: rtl/rt_hcount.sv
// Module: horizontal pixel counter. A 127-state XNOR shift register plus
// one parked all-ones slot gives exactly 128 pixel slots per line. The
// parked slot is the line end; the reload state is never all ones.
module rt_hcount (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_en,
    output logic [rt_pkg::H_W-1:0]  state,
    output logic                    line_end
);
    import rt_pkg::*;

    logic [H_W-1:0] stepped;
    assign stepped  = h_step(state);
    assign line_end = (state == H_PARK);

    // Advance one slot per pixel enable, parking before the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                 state <= H_START;
        else if (pix_en) begin
            if (line_end)           state <= H_START;
            else if (stepped == H_START) state <= H_PARK;
            else                    state <= stepped;
        end
    end
endmodule

// File: rtl/rt_vcount.sv
// Module: vertical line counter. A parity flop halves the line rate and
// the 8-bit XNOR shift register steps after every odd line. The field is
// cut at the decoded last line. Assumes V_TOTAL is even and at most 434.
module rt_vcount #(
    parameter int V_TOTAL = 262
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    output logic [rt_pkg::V_W-1:0]  state,
    output logic                    odd,
    output logic                    field_end
);
    import rt_pkg::*;

    localparam logic [V_W-1:0] V_TERM = v_at((V_TOTAL - 1) / 2);

    assign field_end = odd && (state == V_TERM);

    // Step parity every line and the register after each odd line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= V_START;
            odd   <= 1'b0;
        end else if (adv) begin
            if (field_end) begin
                state <= V_START;
                odd   <= 1'b0;
            end else begin
                odd <= ~odd;
                if (odd) state <= v_step(state);
            end
        end
    end
endmodule

// File: rtl/rt_sr_latch.sv
// Module: clocked set/reset latch. Clear wins over set; both act only on
// an enable edge.
module rt_sr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, set or clear on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (en) begin
            if (clr)      q <= 1'b0;
            else if (set) q <= 1'b1;
        end
    end
endmodule

// File: rtl/raster_timer.sv
// Module: top of the raster timing generator. Decodes exact counter
// states into landmark strobes and drives five set/reset latches (hsync,
// vsync, horizontal and vertical active windows, score band). Assumes all
// slot positions lie within 1..126 and all line positions within 1..V_TOTAL-2.
module raster_timer #(
    parameter int DIV           = 2,
    parameter int H_LEFT_WALL   = 22,
    parameter int H_CENTER      = 62,
    parameter int H_RIGHT_WALL  = 98,
    parameter int H_SYNC_START  = 120,
    parameter int H_ACT_FIRST   = 24,
    parameter int H_ACT_LAST    = 96,
    parameter int V_TOTAL       = 262,
    parameter int V_TOP         = 42,
    parameter int V_BOTTOM      = 232,
    parameter int V_SCORE_FIRST = 44,
    parameter int V_SCORE_LAST  = 68,
    parameter int V_ACT_FIRST   = 40,
    parameter int V_ACT_LAST    = 231,
    parameter int V_SYNC_FIRST  = 258
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       pix_en,
    output logic [6:0] h_state,
    output logic [7:0] v_state,
    output logic       v_odd,
    output logic       left_wall,
    output logic       center_line,
    output logic       right_wall,
    output logic       top_border,
    output logic       bottom_border,
    output logic       score_band,
    output logic       blank,
    output logic       hsync,
    output logic       vsync,
    output logic       csync_n
);
    import rt_pkg::*;

    // Horizontal decode states.
    localparam logic [H_W-1:0] HS_LEFT   = h_at(H_LEFT_WALL);
    localparam logic [H_W-1:0] HS_CENTER = h_at(H_CENTER);
    localparam logic [H_W-1:0] HS_RIGHT  = h_at(H_RIGHT_WALL);
    localparam logic [H_W-1:0] HS_SYNC   = h_at(H_SYNC_START - 1);
    localparam logic [H_W-1:0] HS_ASET   = h_at(H_ACT_FIRST - 1);
    localparam logic [H_W-1:0] HS_ACLR   = h_at(H_ACT_LAST);

    // Vertical decode states and parities, one pair per decoded line.
    localparam logic [V_W-1:0] VS_TOP  = v_at(V_TOP / 2);
    localparam logic           VP_TOP  = 1'(V_TOP % 2);
    localparam logic [V_W-1:0] VS_BOT  = v_at(V_BOTTOM / 2);
    localparam logic           VP_BOT  = 1'(V_BOTTOM % 2);
    localparam logic [V_W-1:0] VS_SSET = v_at((V_SCORE_FIRST - 1) / 2);
    localparam logic           VP_SSET = 1'((V_SCORE_FIRST - 1) % 2);
    localparam logic [V_W-1:0] VS_SCLR = v_at(V_SCORE_LAST / 2);
    localparam logic           VP_SCLR = 1'(V_SCORE_LAST % 2);
    localparam logic [V_W-1:0] VS_ASET = v_at((V_ACT_FIRST - 1) / 2);
    localparam logic           VP_ASET = 1'((V_ACT_FIRST - 1) % 2);
    localparam logic [V_W-1:0] VS_ACLR = v_at(V_ACT_LAST / 2);
    localparam logic           VP_ACLR = 1'(V_ACT_LAST % 2);
    localparam logic [V_W-1:0] VS_YSET = v_at((V_SYNC_FIRST - 1) / 2);
    localparam logic           VP_YSET = 1'((V_SYNC_FIRST - 1) % 2);

    localparam int NL = 5;           // latch count
    localparam int L_HSYNC = 0;
    localparam int L_HACT  = 1;
    localparam int L_VSYNC = 2;
    localparam int L_VACT  = 3;
    localparam int L_SCORE = 4;

    logic line_end, field_end, line_adv;
    logic [NL-1:0] l_en, l_set, l_clr, l_q;

    rt_clk_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en)
    );

    rt_hcount u_h (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .state(h_state), .line_end(line_end)
    );

    assign line_adv = pix_en & line_end;

    rt_vcount #(.V_TOTAL(V_TOTAL)) u_v (
        .clk(clk), .rst_n(rst_n), .adv(line_adv),
        .state(v_state), .odd(v_odd), .field_end(field_end)
    );

    // Landmark strobes: exact-state compares.
    assign left_wall     = (h_state == HS_LEFT);
    assign center_line   = (h_state == HS_CENTER);
    assign right_wall    = (h_state == HS_RIGHT);
    assign top_border    = (v_state == VS_TOP) && (v_odd == VP_TOP);
    assign bottom_border = (v_state == VS_BOT) && (v_odd == VP_BOT);

    // Latch set/clear decodes.
    always_comb begin
        l_en[L_HSYNC]  = pix_en;
        l_set[L_HSYNC] = (h_state == HS_SYNC);
        l_clr[L_HSYNC] = line_end;
        l_en[L_HACT]   = pix_en;
        l_set[L_HACT]  = (h_state == HS_ASET);
        l_clr[L_HACT]  = (h_state == HS_ACLR);
        l_en[L_VSYNC]  = line_adv;
        l_set[L_VSYNC] = (v_state == VS_YSET) && (v_odd == VP_YSET);
        l_clr[L_VSYNC] = field_end;
        l_en[L_VACT]   = line_adv;
        l_set[L_VACT]  = (v_state == VS_ASET) && (v_odd == VP_ASET);
        l_clr[L_VACT]  = (v_state == VS_ACLR) && (v_odd == VP_ACLR);
        l_en[L_SCORE]  = line_adv;
        l_set[L_SCORE] = (v_state == VS_SSET) && (v_odd == VP_SSET);
        l_clr[L_SCORE] = (v_state == VS_SCLR) && (v_odd == VP_SCLR);
    end

    for (genvar g = 0; g < NL; g++) begin : g_latch
        rt_sr_latch u_l (
            .clk(clk), .rst_n(rst_n), .en(l_en[g]),
            .set(l_set[g]), .clr(l_clr[g]), .q(l_q[g])
        );
    end

    assign hsync      = l_q[L_HSYNC];
    assign vsync      = l_q[L_VSYNC];
    assign score_band = l_q[L_SCORE];
    assign blank      = ~(l_q[L_HACT] & l_q[L_VACT]);
    assign csync_n    = ~(hsync | vsync);
endmodule

// File: rtl/raster_timer_chk.sv
// Module: assertion checker for raster_timer, attached with bind.
// Assumes the default parameter set (DIV >= 2).
module raster_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_en,
    input logic [6:0] h_state,
    input logic [7:0] v_state,
    input logic       left_wall,
    input logic       center_line,
    input logic       right_wall,
    input logic       blank,
    input logic       hsync,
    input logic       vsync
);
    a_r1_enable_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en);

    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(h_state));

    a_r2_park_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && h_state == 7'h7F) |=> (h_state == 7'h00));

    a_r3_line_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(v_state) && $past(rst_n)) |-> ($past(h_state) == 7'h7F && $past(pix_en)));

    a_r4_single_column: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_wall, center_line, right_wall}));

    a_r6_sync_end: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && h_state == 7'h7F) |=> !hsync);

    a_r7_vsync_line_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vsync) && $past(rst_n)) |-> (h_state == 7'h00));

    a_r9_blank_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> blank);
endmodule

bind raster_timer raster_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_state(h_state),
    .v_state(v_state), .left_wall(left_wall), .center_line(center_line),
    .right_wall(right_wall), .blank(blank), .hsync(hsync), .vsync(vsync)
);

// File: tb/raster_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference built from clock-edge counting, compared
// on every falling edge against all outputs of raster_timer.
module raster_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en, v_odd, left_wall, center_line, right_wall;
    logic top_border, bottom_border, score_band, blank, hsync, vsync, csync_n;
    logic [6:0] h_state;
    logic [7:0] v_state;

    int n_vec = 0;
    int n_bad = 0;
    int edges = 0;      // edges since reset released
    bit valid = 0;
    bit done  = 0;
    int cyc   = 0;
    int hseq[128];
    int vseq[262];

    always #2 clk = ~clk;

    raster_timer dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_state(h_state),
        .v_state(v_state), .v_odd(v_odd), .left_wall(left_wall),
        .center_line(center_line), .right_wall(right_wall),
        .top_border(top_border), .bottom_border(bottom_border),
        .score_band(score_band), .blank(blank), .hsync(hsync),
        .vsync(vsync), .csync_n(csync_n)
    );

    task automatic chk(input string req, input string nm, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            if (n_bad < 20)
                $display("FAIL %s %s at edge %0d: actual %0d expected %0d",
                         req, nm, edges, act, exp);
        end
    endtask

    // Reference model: edge count since reset.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin edges <= 0; valid <= 1; end
        else        edges <= edges + 1;
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (valid && !done) begin
            int p, slot, line;
            p    = edges / 2;
            slot = p % 128;
            line = (p / 128) % 262;
            chk("R1", "pix_en", pix_en, (rst_n && edges % 2 == 1) ? 1 : 0);
            chk("R2", "h_state", h_state, hseq[slot]);
            chk("R3", "v_state", v_state, vseq[line]);
            chk("R3", "v_odd", v_odd, line % 2);
            chk("R4", "left_wall", left_wall, slot == 22);
            chk("R4", "center_line", center_line, slot == 62);
            chk("R4", "right_wall", right_wall, slot == 98);
            chk("R5", "top_border", top_border, line == 42);
            chk("R5", "bottom_border", bottom_border, line == 232);
            chk("R5", "score_band", score_band, line >= 44 && line <= 68);
            chk("R6", "hsync", hsync, slot >= 120);
            chk("R7", "vsync", vsync, line >= 258);
            chk("R8", "csync_n", csync_n, !(slot >= 120 || line >= 258));
            chk("R9", "blank", blank,
                !(slot >= 24 && slot <= 96 && line >= 40 && line <= 231));
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired: actual %0d expected below 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic reset_state_check(input string tag);
        chk(tag, "reset h_state", h_state, 0);
        chk(tag, "reset v_state", v_state, 0);
        chk(tag, "reset hsync", hsync, 0);
        chk(tag, "reset vsync", vsync, 0);
        chk(tag, "reset csync_n", csync_n, 1);
        chk(tag, "reset blank", blank, 1);
        chk(tag, "reset pix_en", pix_en, 0);
    endtask

    initial begin
        int s;
        // Horizontal sequence from R2.
        s = 0;
        hseq[0] = 0;
        for (int i = 1; i < 127; i++) begin
            s = ((s << 1) & 127) | ((((s >> 6) ^ s) & 1) ^ 1);
            hseq[i] = s;
        end
        hseq[127] = 127;
        // Vertical sequence from R3: two lines per state.
        s = 0;
        for (int l = 0; l < 262; l++) begin
            vseq[l] = s;
            if (l % 2 == 1) s = ((s << 1) & 255) | ((((s >> 7) ^ (s >> 4)) & 1) ^ 1);
        end

        repeat (3) @(negedge clk);
        reset_state_check("R10");
        rst_n = 1'b1;
        // Full field plus wrap into the next one.
        repeat (67072 + 300) @(negedge clk);
        // Restart, then reset again in the middle of vertical sync.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (259 * 256 + 40) @(negedge clk);
        chk("R7", "vsync before reset", vsync, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reset_state_check("R10");
        rst_n = 1'b1;
        repeat (600) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule